// File: doc/BRIEF.md
# Paged load/store sequencer

This block carries out the memory-referencing instructions of a 16-bit, word-addressed machine whose 64K-word space is split into 128 pages of 512 words. On a start strobe it takes the page number of the program counter, the instruction word, a base-register value and a source-register value. It forms the effective address and runs one or two accesses on a single-port memory that signals completion with a ready handshake. When the instruction ends it returns a register write (index, data, enable), a flag update and a one-cycle done pulse.

The block supports four ways of forming an address. In-page direct addressing joins the page number to a 9-bit offset instead of adding them. Indirect addressing reads a pointer word first and then uses it as the operand address. Base-plus-offset addressing adds a zero-extended 6-bit field to the base value. The load-effective-address form writes the in-page address to a register without touching memory. Fetch and arithmetic are handled elsewhere in the pipeline.

Top module: `paged_ldst_seq`

## Requirements
- R1: After reset, mem_rd, mem_wr, rf_we, flag_we, done and busy are all low.
- R2: Opcodes 0010 (load) and 0011 (store) access the single address {pc_page, instr[8:0]}, with no carry into the page bits.
- R3: Opcodes 0110 (load) and 0111 (store) access base_val + zero-extended instr[5:0], modulo 2^16. For example, base 16'h2035 with offset 12 gives 16'h2041.
- R4: Opcodes 1010 (load) and 1011 (store) first read the word at {pc_page, instr[8:0]}. The second access, a read for 1010 and a write for 1011, goes to the address held in that word.
- R5: Opcode 1110 makes no memory access. It writes {pc_page, instr[8:0]} to register instr[11:9], and done rises in the first cycle after start is sampled.
- R6: A load writes the word returned by its final read into register instr[11:9], with rf_we high in the cycle after that read's ready.
- R7: A store writes the src_val captured at start to the effective address. It raises neither rf_we nor flag_we.
- R8: Every register write also raises flag_we. flag_nzp = {N,Z,P} is 3'b100 for a negative value, 3'b010 for zero and 3'b001 for a positive value.
- R9: A pending request holds mem_addr (and mem_wdata for writes) stable until ready is sampled high. mem_rd and mem_wr are never high together.
- R10: Start is ignored while busy. Any opcode not listed above gives a done pulse with no access and no register or flag write.
- R11: Done is a one-cycle pulse that coincides with rf_we. Each access of the instruction adds (latency + 1) cycles before done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (sampled only when idle) |
| pc_page | input | 7 | Page number of the executing instruction's program counter |
| instr | input | 16 | Instruction word |
| base_val | input | 16 | Value of the selected base register |
| src_val | input | 16 | Value of the register to be stored |
| busy | output | 1 | Instruction in progress |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_rdata | input | 16 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Current access completes this cycle |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | 3 | Register index to write |
| rf_data | output | 16 | Register write data |
| flag_we | output | 1 | Flag update strobe |
| flag_nzp | output | 3 | New {N,Z,P} flags |
| done | output | 1 | Instruction complete |

## Verification
Each of the seven opcodes is swept over program-counter pages at both ends of the space and in-page offsets of 0, 1, the maximum and mixed patterns. This separates joining the page bits from adding them, because an adding bug would carry into the page. Base-plus-offset is tried with bases near 0, 16'h7FFF, 16'h8000 and 16'hFFFF, so a sign-extension or wrap mistake changes the address. The memory answers with a known function of the address and a latency of 0 to 3 cycles. This distinguishes one access from two, read from write, early completion from waiting on ready, and negative, zero and positive loaded values. Unknown opcodes and a start raised mid-instruction check that nothing extra happens.

// File: rtl/plds_pkg.sv
package plds_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PTR  = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;

    typedef enum logic [2:0] {
        AM_NONE   = 3'd0,
        AM_DIRECT = 3'd1,
        AM_INDIR  = 3'd2,
        AM_BASE   = 3'd3,
        AM_LEA    = 3'd4
    } amode_e;

    typedef struct packed {
        amode_e mode;
        logic   is_store;
    } op_info_t;

    localparam int OPC_W = 4;

    function automatic op_info_t decode_op(input logic [OPC_W-1:0] opc);
        op_info_t r;
        case (opc)
            4'b0010: r = '{mode: AM_DIRECT, is_store: 1'b0};
            4'b0011: r = '{mode: AM_DIRECT, is_store: 1'b1};
            4'b1010: r = '{mode: AM_INDIR,  is_store: 1'b0};
            4'b1011: r = '{mode: AM_INDIR,  is_store: 1'b1};
            4'b0110: r = '{mode: AM_BASE,   is_store: 1'b0};
            4'b0111: r = '{mode: AM_BASE,   is_store: 1'b1};
            4'b1110: r = '{mode: AM_LEA,    is_store: 1'b0};
            default: r = '{mode: AM_NONE,   is_store: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/plds_ea_calc.sv
module plds_ea_calc #(
    parameter int WORD_W     = 16,
    parameter int PAGE_OFS_W = 9,
    parameter int BASE_OFS_W = 6,
    localparam int PAGE_W    = WORD_W - PAGE_OFS_W
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] base,
    output logic [WORD_W-1:0] ea_page,
    output logic [WORD_W-1:0] ea_base
);
    // In-page form: page bits are joined, never added.
    assign ea_page = {page, instr[PAGE_OFS_W-1:0]};
    // Base form: unsigned offset, wraps modulo 2^WORD_W.
    assign ea_base = base + {{(WORD_W-BASE_OFS_W){1'b0}}, instr[BASE_OFS_W-1:0]};
endmodule

// File: rtl/plds_flag_gen.sv
module plds_flag_gen #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] value,
    output logic [2:0]        nzp
);
    logic neg, zero;
    assign neg  = value[WORD_W-1];
    assign zero = (value == '0);
    assign nzp  = {neg, zero, ~neg & ~zero};
endmodule

// File: rtl/paged_ldst_seq.sv
module paged_ldst_seq
    import plds_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int PAGE_OFS_W = 9,
    parameter int BASE_OFS_W = 6,
    parameter int REG_IDX_W  = 3,
    localparam int PAGE_W    = WORD_W - PAGE_OFS_W,
    localparam int OPC_LSB   = WORD_W - OPC_W,
    localparam int IDX_MSB   = OPC_LSB - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [PAGE_W-1:0]    pc_page,
    input  logic [WORD_W-1:0]    instr,
    input  logic [WORD_W-1:0]    base_val,
    input  logic [WORD_W-1:0]    src_val,
    output logic                 busy,
    output logic [WORD_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    output logic                 mem_rd,
    output logic                 mem_wr,
    input  logic [WORD_W-1:0]    mem_rdata,
    input  logic                 mem_ready,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_idx,
    output logic [WORD_W-1:0]    rf_data,
    output logic                 flag_we,
    output logic [2:0]           flag_nzp,
    output logic                 done
);

    typedef struct packed {
        seq_state_e           st;
        logic                 is_store;
        logic [WORD_W-1:0]    addr;
        logic [WORD_W-1:0]    wdata;
        logic [REG_IDX_W-1:0] idx;
        logic                 rf_we;
        logic [WORD_W-1:0]    rf_data;
        logic                 flag_we;
        logic [2:0]           nzp;
        logic                 done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [WORD_W-1:0] ea_page, ea_base, wb_val;
    logic [2:0]        wb_nzp;
    op_info_t          info;

    assign info = decode_op(instr[WORD_W-1:OPC_LSB]);

    plds_ea_calc #(
        .WORD_W(WORD_W), .PAGE_OFS_W(PAGE_OFS_W), .BASE_OFS_W(BASE_OFS_W)
    ) i_ea (
        .page(pc_page), .instr(instr), .base(base_val),
        .ea_page(ea_page), .ea_base(ea_base)
    );

    // Value written back: in-page address when idle (LEA), memory word otherwise.
    assign wb_val = (r_q.st == ST_IDLE) ? ea_page : mem_rdata;

    plds_flag_gen #(.WORD_W(WORD_W)) i_flags (.value(wb_val), .nzp(wb_nzp));

    always_comb begin
        r_d         = r_q;
        r_d.rf_we   = 1'b0;
        r_d.flag_we = 1'b0;
        r_d.done    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.idx      = instr[IDX_MSB -: REG_IDX_W];
                    r_d.wdata    = src_val;
                    r_d.is_store = info.is_store;
                    case (info.mode)
                        AM_DIRECT: begin
                            r_d.addr = ea_page;
                            r_d.st   = ST_DATA;
                        end
                        AM_INDIR: begin
                            r_d.addr = ea_page;
                            r_d.st   = ST_PTR;
                        end
                        AM_BASE: begin
                            r_d.addr = ea_base;
                            r_d.st   = ST_DATA;
                        end
                        AM_LEA: begin
                            r_d.rf_we   = 1'b1;
                            r_d.rf_data = wb_val;
                            r_d.flag_we = 1'b1;
                            r_d.nzp     = wb_nzp;
                            r_d.done    = 1'b1;
                        end
                        default: r_d.done = 1'b1;
                    endcase
                end
            end
            ST_PTR: begin
                if (mem_ready) begin
                    r_d.addr = mem_rdata;
                    r_d.st   = ST_DATA;
                end
            end
            ST_DATA: begin
                if (mem_ready) begin
                    if (!r_q.is_store) begin
                        r_d.rf_we   = 1'b1;
                        r_d.rf_data = wb_val;
                        r_d.flag_we = 1'b1;
                        r_d.nzp     = wb_nzp;
                    end
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign mem_rd    = (r_q.st == ST_PTR) || ((r_q.st == ST_DATA) && !r_q.is_store);
    assign mem_wr    = (r_q.st == ST_DATA) && r_q.is_store;
    assign rf_we     = r_q.rf_we;
    assign rf_idx    = r_q.idx;
    assign rf_data   = r_q.rf_data;
    assign flag_we   = r_q.flag_we;
    assign flag_nzp  = r_q.nzp;
    assign done      = r_q.done;

    // R9: read and write requests exclusive
    p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9: an unanswered read keeps its address
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    // R9: an unanswered write keeps address and data
    p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    // R8: exactly one flag set on each update
    p_flag_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> ($countones(flag_nzp) == 1));

    // R7: flags move only together with a register write
    p_flag_with_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> rf_we);

    // R11: register write lands in the completion cycle
    p_reg_at_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> done);

    // R10: no memory traffic while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

endmodule

// File: tb/test_paged_ldst_seq.sv
`timescale 1ns/1ps
module test_paged_ldst_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  pc_page = '0;
    logic [15:0] instr = '0, base_val = '0, src_val = '0;
    logic        busy, mem_rd, mem_wr, mem_ready, rf_we, flag_we, done;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, rf_data;
    logic [2:0]  rf_idx, flag_nzp;

    int n_chk = 0, n_fail = 0;
    int lat = 0, cnt = 0, n_acc = 0, n_done = 0, n_rfwe = 0;
    logic [15:0] lg_addr [4];
    logic [15:0] lg_data [4];
    logic        lg_wr   [4];
    logic [15:0] last_rf;
    logic        c_rf_we, c_flag_we;
    logic [2:0]  c_idx, c_nzp;
    logic [15:0] c_data;

    always #2.5 clk = ~clk;

    paged_ldst_seq i_paged_ldst_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .pc_page(pc_page),
        .instr(instr), .base_val(base_val), .src_val(src_val), .busy(busy),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rf_we(rf_we), .rf_idx(rf_idx),
        .rf_data(rf_data), .flag_we(flag_we), .flag_nzp(flag_nzp), .done(done)
    );

    function automatic logic [15:0] memf(input logic [15:0] a);
        return (a[3:0] == 4'h0) ? 16'h0000 : (a ^ 16'hC3A5);
    endfunction

    function automatic logic [2:0] nzp_of(input logic [15:0] v);
        return v[15] ? 3'b100 : (v == 16'h0) ? 3'b010 : 3'b001;
    endfunction

    // Memory model: fixed latency, contents a function of the address.
    assign mem_ready = (mem_rd || mem_wr) && (cnt == lat);
    assign mem_rdata = memf(mem_addr);

    always @(posedge clk) begin
        if (!rst_n) cnt <= 0;
        else if ((mem_rd || mem_wr) && !mem_ready) cnt <= cnt + 1;
        else cnt <= 0;
        if (rst_n && (mem_rd || mem_wr) && mem_ready) begin
            lg_addr[n_acc % 4] <= mem_addr;
            lg_data[n_acc % 4] <= mem_wdata;
            lg_wr[n_acc % 4]   <= mem_wr;
            n_acc <= n_acc + 1;
        end
    end

    always @(negedge clk) begin
        if (done) n_done <= n_done + 1;
        if (rf_we) begin
            n_rfwe  <= n_rfwe + 1;
            last_rf <= rf_data;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] p, input logic [15:0] ins, input logic [15:0] b,
                          input logic [15:0] s, input int l, output int waits);
        lat = l;
        @(negedge clk);
        pc_page = p[15:9]; instr = ins; base_val = b; src_val = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waits = 0;
        while (!done && waits < 60) begin
            @(negedge clk);
            waits++;
        end
        chk("R11", done, 1'b1);
        c_rf_we = rf_we; c_flag_we = flag_we; c_idx = rf_idx; c_nzp = flag_nzp; c_data = rf_data;
        @(negedge clk);
        chk("R11", done, 1'b0);
    endtask

    task automatic check_op(input logic [15:0] p, input logic [15:0] ins, input logic [15:0] b,
                            input logic [15:0] s, input int l);
        logic [3:0]  opc = ins[15:12];
        logic [15:0] page_ea = {p[15:9], ins[8:0]};
        logic [15:0] base_ea = b + {10'b0, ins[5:0]};
        logic [15:0] a0 = 16'h0, fin = 16'h0, val;
        int exp_n = 0, n0, waits;
        bit st = 0, is_lea = 0, valid = 1;
        string rq;
        case (opc)
            4'b0010, 4'b0011: begin rq = "R2"; exp_n = 1; a0 = page_ea; fin = a0; st = opc[0]; end
            4'b0110, 4'b0111: begin rq = "R3"; exp_n = 1; a0 = base_ea; fin = a0; st = opc[0]; end
            4'b1010, 4'b1011: begin rq = "R4"; exp_n = 2; a0 = page_ea; fin = memf(page_ea); st = opc[0]; end
            4'b1110:          begin rq = "R5"; is_lea = 1; end
            default:          begin rq = "R10"; valid = 0; end
        endcase
        n0 = n_acc;
        run_op(p, ins, b, s, l, waits);
        chk(rq, n_acc - n0, exp_n);
        chk("R11", waits, exp_n * (l + 1));
        if (exp_n >= 1) begin
            chk(rq, lg_addr[n0 % 4], a0);
            chk(rq, lg_wr[n0 % 4], (exp_n == 1) ? st : 1'b0);
        end
        if (exp_n == 2) begin
            chk("R4", lg_addr[(n0 + 1) % 4], fin);
            chk("R4", lg_wr[(n0 + 1) % 4], st);
        end
        if (!valid || st) begin
            if (st) chk("R7", lg_data[(n0 + exp_n - 1) % 4], s);
            chk(st ? "R7" : "R10", c_rf_we, 1'b0);
            chk(st ? "R7" : "R10", c_flag_we, 1'b0);
        end else begin
            val = is_lea ? page_ea : memf(fin);
            chk(is_lea ? "R5" : "R6", c_rf_we, 1'b1);
            chk(is_lea ? "R5" : "R6", c_idx, ins[11:9]);
            chk(is_lea ? "R5" : "R6", c_data, val);
            chk("R8", c_flag_we, 1'b1);
            chk("R8", c_nzp, nzp_of(val));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] pcs [4]  = '{16'h0000, 16'h2081, 16'h7FFF, 16'hFE00};
        logic [8:0]  o9  [5]  = '{9'h000, 9'h001, 9'h1FF, 9'h155, 9'h100};
        logic [15:0] bs  [5]  = '{16'h2035, 16'h0000, 16'hFFFF, 16'h8000, 16'h7FC1};
        logic [5:0]  o6  [4]  = '{6'd0, 6'd12, 6'd63, 6'd1};
        logic [3:0]  pops [5] = '{4'b0010, 4'b0011, 4'b1010, 4'b1011, 4'b1110};
        logic [3:0]  bad  [4] = '{4'b0000, 4'b0001, 4'b0101, 4'b1111};
        int n0, d0, r0, w;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", {busy, mem_rd, mem_wr, rf_we, flag_we, done}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {busy, mem_rd, mem_wr, rf_we, flag_we, done}, 6'b0);

        // R2, R4, R5: in-page modes
        for (int k = 0; k < 5; k++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 5; j++)
                    check_op(pcs[i], {pops[k], 3'((i + j + k) % 8), o9[j]}, 16'h0,
                             pcs[i] ^ {7'h0, o9[j]} ^ 16'h0F0F, (i + j + k) % 4);

        // R3: base plus unsigned offset, both directions
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 4; j++)
                    check_op(16'h4200, {k ? 4'b0111 : 4'b0110, 3'((i + j) % 8), 3'(i), o6[j]},
                             bs[i], bs[i] ^ 16'h5A5A, (i + j) % 3);

        // R3: worked example 16'h2035 + 12
        n0 = n_acc;
        run_op(16'h0000, {4'b0110, 3'd1, 3'd6, 6'd12}, 16'h2035, 16'h0, 0, w);
        chk("R3", lg_addr[n0 % 4], 16'h2041);

        // R10: unknown opcodes do nothing but finish
        for (int k = 0; k < 4; k++)
            check_op(16'h1200, {bad[k], 12'hABC}, 16'h1111, 16'h2222, 1);

        // R10: start while busy is ignored
        lat = 3; n0 = n_acc; d0 = n_done; r0 = n_rfwe;
        @(negedge clk);
        pc_page = 7'h10; instr = {4'b0010, 3'd2, 9'h033}; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        instr = {4'b1110, 3'd5, 9'h0F0}; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 10; t++) @(negedge clk);
        chk("R10", n_done - d0, 1);
        chk("R10", n_acc - n0, 1);
        chk("R10", n_rfwe - r0, 1);
        chk("R10", last_rf, memf({7'h10, 9'h033}));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule